// File: doc/BRIEF.md
# Gate-Current Profile Sequencer

This block drives the current-setting code of a gate-driver output stage through a timed series of setpoints each time the PWM command changes level. A rising command runs the turn-on list of the active profile and a falling command runs the turn-off list. Each list is an ordered set of segments, and each segment gives a current amplitude code and the number of clock cycles it holds. The turn-on list opens with a pre-charge step and then shapes the slopes through the Miller plateau. The turn-off list opens with a pre-discharge step and then applies controlled discharge steps. When a turn-off list is finished, the block engages the active Miller clamp.

Many profiles sit in a small register file. A profile index, derived outside the block from quantised bus voltage, switch current and temperature, is sampled at every command edge. A sequence therefore runs to completion on one profile, and a change of operating point takes effect at the next edge. The register file is loaded through a plain address/data/write-enable port. Writes are refused while a sequence is running, so a profile cannot change under a running sequence.

Top module: `gate_current_sequencer`

## Requirements
- R1: During and after synchronous active-low reset, `dac_code` is 0, `seq_busy` is 0 and `clamp_en` is 1. The command level remembered by the block is low.
- R2: The block samples `pwm_cmd` at each clock edge. When the sampled level differs from the level at the previous edge, a sequence starts. A high level selects the turn-on list and a low level selects the turn-off list. In the cycle after that edge, `dac_code` shows the first usable segment's amplitude and `seq_busy` is 1.
- R3: Usable segments are played in ascending slot order. Each one holds its amplitude on `dac_code` for exactly its duration in clock cycles.
- R4: A segment is usable only when its slot is below the list's count field and its duration is non-zero. Unusable slots take no cycles. A count larger than the list length acts as the list length.
- R5: When the last usable segment has run its time, `seq_busy` falls. `dac_code` then keeps the final amplitude until the next edge. If an edge finds no usable segment, `seq_busy` stays 0 and `dac_code` keeps its value.
- R6: The profile index on `prof_sel` is captured at the starting edge. Later changes of `prof_sel` do not affect the running sequence. An index at or above NUM_PROF selects profile 0.
- R7: A command edge during a sequence abandons it at once. The new list starts from its first usable segment.
- R8: `clamp_en` is 0 from the first cycle of every turn-on sequence. It is 1 from the cycle in which a turn-off sequence ends, or in which a turn-off edge finds no usable segment. An aborted turn-off leaves it at 0.
- R9: `cfg_addr` is {profile, word}, with the word field in the low WORD_W bits. Words 0..N_ON-1 are turn-on slots. Words N_ON..N_ON+N_OFF-1 are turn-off slots. Word N_ON+N_OFF is the turn-on count and the next word is the turn-off count. A slot word is {amplitude, duration}, with the duration in the low DUR_W bits. A count word takes its low DUR_W bits.
- R10: A write is ignored when `seq_busy` is 1 in its cycle. A write is also ignored when its profile or word field is out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_cmd | input | 1 | Switch command; each level change starts a sequence |
| prof_sel | input | IDX_W | Operating-point profile index |
| cfg_we | input | 1 | Profile memory write strobe |
| cfg_addr | input | IDX_W+WORD_W | {profile, word} write address |
| cfg_wdata | input | AMP_W+DUR_W | Write data |
| dac_code | output | AMP_W | Current amplitude code for the output stage |
| seq_busy | output | 1 | A sequence is running |
| clamp_en | output | 1 | Active Miller clamp enable |

## Verification
The bench builds the block with eight profiles and a 4-bit index. This makes indices 8 to 15 reachable, so the fallback to profile 0 is exercised, and writes to nonexistent profiles can be tried. The list lengths stay at six and five. A 5-bit duration keeps segments short, so many complete sequences, aborts and count fields above the list length occur in a few thousand cycles. Random toggling, random selection and random writes, some of them while a sequence is busy, run alongside directed edges at chosen cycles.

// File: rtl/gcs_pkg.sv
// Shared definitions for the gate-current sequencer.
// Assumes: list lengths are small compile-time constants.
package gcs_pkg;

    // Direction of a switching sequence, equal to the commanded level.
    typedef enum logic {
        DIR_OFF = 1'b0,
        DIR_ON  = 1'b1
    } gate_dir_e;

    // Number of slot lanes needed to carry either list.
    function automatic int lane_count(input int n_on, input int n_off);
        return (n_on > n_off) ? n_on : n_off;
    endfunction

    // Words one profile occupies: all slots plus two count words.
    function automatic int profile_words(input int n_on, input int n_off);
        return n_on + n_off + 2;
    endfunction

endpackage

// File: rtl/gcs_profile_mem.sv
// Profile register file.
// Stores, for every profile, the turn-on and turn-off slot lists and their
// count fields. One write port is provided. A combinational read port
// presents the whole list of one profile and direction as lanes, with lanes
// beyond that list's length forced to zero.
// Assumes: NUM_PROF >= 2 and IDX_W >= clog2(NUM_PROF). The storage has no
// reset; it holds what was written.
module gcs_profile_mem
    import gcs_pkg::*;
#(
    parameter int NUM_PROF = 133,
    parameter int IDX_W    = 8,
    parameter int N_ON     = 6,
    parameter int N_OFF    = 5,
    parameter int AMP_W    = 8,
    parameter int DUR_W    = 8,
    localparam int LANES   = lane_count(N_ON, N_OFF),
    localparam int WORDS   = profile_words(N_ON, N_OFF),
    localparam int WORD_W  = $clog2(WORDS),
    localparam int ADDR_W  = IDX_W + WORD_W,
    localparam int DATA_W  = AMP_W + DUR_W
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic                         wr_block,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [IDX_W-1:0]             rd_prof,
    input  gate_dir_e                    rd_dir,
    output logic [LANES-1:0][AMP_W-1:0]  rd_amp,
    output logic [LANES-1:0][DUR_W-1:0]  rd_dur,
    output logic [DUR_W-1:0]             rd_count
);

    localparam int PW    = $clog2(NUM_PROF);
    localparam int SLOTS = N_ON + N_OFF;

    logic [AMP_W-1:0] amp_mem   [NUM_PROF][SLOTS];
    logic [DUR_W-1:0] dur_mem   [NUM_PROF][SLOTS];
    logic [DUR_W-1:0] cnt_on_m  [NUM_PROF];
    logic [DUR_W-1:0] cnt_off_m [NUM_PROF];

    logic [IDX_W-1:0]  wr_prof;
    logic [WORD_W-1:0] wr_word;
    logic              wr_ok;
    logic [PW-1:0]     rd_p;

    // Split the address and qualify the write (R9, R10).
    always_comb begin
        wr_prof = wr_addr[ADDR_W-1:WORD_W];
        wr_word = wr_addr[WORD_W-1:0];
        wr_ok   = wr_en && !wr_block
                  && (int'(wr_prof) < NUM_PROF)
                  && (int'(wr_word) < WORDS);
    end

    // Store a slot word or a count word.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            if (int'(wr_word) < SLOTS) begin
                amp_mem[wr_prof[PW-1:0]][wr_word] <= wr_data[DATA_W-1:DUR_W];
                dur_mem[wr_prof[PW-1:0]][wr_word] <= wr_data[DUR_W-1:0];
            end else if (int'(wr_word) == SLOTS) begin
                cnt_on_m[wr_prof[PW-1:0]] <= wr_data[DUR_W-1:0];
            end else begin
                cnt_off_m[wr_prof[PW-1:0]] <= wr_data[DUR_W-1:0];
            end
        end
    end

    // An out-of-range index falls back to profile 0 (R6).
    always_comb begin
        rd_p = (int'(rd_prof) < NUM_PROF) ? rd_prof[PW-1:0] : '0;
    end

    // Pick the count field of the requested direction.
    always_comb begin
        rd_count = (rd_dir == DIR_ON) ? cnt_on_m[rd_p] : cnt_off_m[rd_p];
    end

    // One lane per slot position; a lane beyond a list's length reads as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AMP_W-1:0] on_amp, off_amp;
        logic [DUR_W-1:0] on_dur, off_dur;

        if (g < N_ON) begin : g_on
            assign on_amp = amp_mem[rd_p][g];
            assign on_dur = dur_mem[rd_p][g];
        end else begin : g_on_pad
            assign on_amp = '0;
            assign on_dur = '0;
        end

        if (g < N_OFF) begin : g_off
            assign off_amp = amp_mem[rd_p][N_ON + g];
            assign off_dur = dur_mem[rd_p][N_ON + g];
        end else begin : g_off_pad
            assign off_amp = '0;
            assign off_dur = '0;
        end

        // Route the lane of the requested direction.
        always_comb begin
            rd_amp[g] = (rd_dir == DIR_ON) ? on_amp : off_amp;
            rd_dur[g] = (rd_dir == DIR_ON) ? on_dur : off_dur;
        end
    end

endmodule

// File: rtl/gcs_seg_pick.sv
// Next-segment finder.
// Returns the lowest slot at or above 'from' that lies below the count field
// and has a non-zero duration, so that unusable slots cost no cycles.
// Assumes: LANES is small; the search is a flat priority chain.
module gcs_seg_pick #(
    parameter int LANES  = 6,
    parameter int DUR_W  = 8,
    localparam int SEG_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0][DUR_W-1:0] dur,
    input  logic [DUR_W-1:0]            count,
    input  logic [SEG_W-1:0]            from,
    output logic                        found,
    output logic [SEG_W-1:0]            idx
);

    // Scan downward so that the lowest qualifying slot is kept (R3, R4).
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if ((i >= int'(from)) && (i < int'(count)) && (dur[i] != '0)) begin
                found = 1'b1;
                idx   = SEG_W'(i);
            end
        end
    end

endmodule

// File: rtl/gcs_seq_core.sv
// Sequencing core.
// Detects command level changes, captures the profile index, walks the
// usable segments of the chosen list, and times each segment with a
// down-counter. It drives the amplitude code, the busy flag and the clamp.
// Assumes: the read port it addresses is combinational, so the first segment
// can be loaded on the same edge that detects the command change.
module gcs_seq_core
    import gcs_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LANES    = 6,
    parameter int AMP_W    = 8,
    parameter int DUR_W    = 8,
    localparam int SEG_W   = $clog2(LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwm_cmd,
    input  logic [IDX_W-1:0]            prof_sel,
    output logic [IDX_W-1:0]            rd_prof,
    output gate_dir_e                   rd_dir,
    input  logic [LANES-1:0][AMP_W-1:0] rd_amp,
    input  logic [LANES-1:0][DUR_W-1:0] rd_dur,
    input  logic [DUR_W-1:0]            rd_count,
    output logic [AMP_W-1:0]            dac_code,
    output logic                        seq_busy,
    output logic                        clamp_en
);

    logic             pwm_q;
    logic [IDX_W-1:0] prof_q;
    gate_dir_e        dir_q;
    logic [SEG_W-1:0] seg_q;
    logic [DUR_W-1:0] cnt_q;
    logic             busy_q;
    logic [AMP_W-1:0] dac_q;
    logic             clamp_q;

    logic             start;
    logic [SEG_W-1:0] pk_from;
    logic             pk_found;
    logic [SEG_W-1:0] pk_idx;

    // An edge is seen when the sampled level differs from the last one (R2, R7).
    always_comb begin
        start   = pwm_cmd ^ pwm_q;
        rd_prof = start ? prof_sel : prof_q;
        rd_dir  = start ? gate_dir_e'(pwm_cmd) : dir_q;
        pk_from = start ? '0 : seg_q + SEG_W'(1);
    end

    gcs_seg_pick #(
        .LANES (LANES),
        .DUR_W (DUR_W)
    ) pick_i (
        .dur   (rd_dur),
        .count (rd_count),
        .from  (pk_from),
        .found (pk_found),
        .idx   (pk_idx)
    );

    // Sequence state: edge capture, segment timing and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            prof_q  <= '0;
            dir_q   <= DIR_OFF;
            seg_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            dac_q   <= '0;
            clamp_q <= 1'b1;
        end else begin
            pwm_q <= pwm_cmd;
            if (start) begin
                prof_q <= prof_sel;
                dir_q  <= gate_dir_e'(pwm_cmd);
                if (pwm_cmd) begin
                    clamp_q <= 1'b0;
                end
                if (pk_found) begin
                    seg_q  <= pk_idx;
                    dac_q  <= rd_amp[pk_idx];
                    cnt_q  <= rd_dur[pk_idx] - DUR_W'(1);
                    busy_q <= 1'b1;
                end else begin
                    busy_q <= 1'b0;
                    if (!pwm_cmd) begin
                        clamp_q <= 1'b1;
                    end
                end
            end else if (busy_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - DUR_W'(1);
                end else if (pk_found) begin
                    seg_q <= pk_idx;
                    dac_q <= rd_amp[pk_idx];
                    cnt_q <= rd_dur[pk_idx] - DUR_W'(1);
                end else begin
                    busy_q <= 1'b0;
                    if (dir_q == DIR_OFF) begin
                        clamp_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign dac_code = dac_q;
    assign seq_busy = busy_q;
    assign clamp_en = clamp_q;

    // R3: a segment that still has cycles left keeps its amplitude.
    assert_segment_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (cnt_q != '0) && !start) |=> $stable(dac_q));

    // R4: the finder only hands back a slot with time left on it, at or past the search point.
    assert_pick_usable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_found |-> ((rd_dur[pk_idx] != '0) && (pk_idx >= pk_from)));

    // R5: while idle and without an edge, the amplitude code holds.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> $stable(dac_q));

    // R8: the clamp is never on while the command level is high.
    assert_clamp_off_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_q |-> !clamp_q);

    // R8: a turn-off sequence that runs out engages the clamp in the same cycle.
    assert_clamp_after_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && (dir_q == DIR_OFF)) |-> clamp_q);

endmodule

// File: rtl/gate_current_sequencer.sv
// Gate-current profile sequencer, top level.
// Joins the profile register file and the sequencing core. Writes are
// refused whenever the core reports a sequence in progress.
// Assumes: prof_sel is already quantised and stable enough to sample.
module gate_current_sequencer
    import gcs_pkg::*;
#(
    parameter int NUM_PROF = 133,
    parameter int IDX_W    = 8,
    parameter int N_ON     = 6,
    parameter int N_OFF    = 5,
    parameter int AMP_W    = 8,
    parameter int DUR_W    = 8,
    localparam int LANES   = lane_count(N_ON, N_OFF),
    localparam int WORD_W  = $clog2(profile_words(N_ON, N_OFF)),
    localparam int ADDR_W  = IDX_W + WORD_W,
    localparam int DATA_W  = AMP_W + DUR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_cmd,
    input  logic [IDX_W-1:0]  prof_sel,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [AMP_W-1:0]  dac_code,
    output logic              seq_busy,
    output logic              clamp_en
);

    logic [IDX_W-1:0]            rd_prof;
    gate_dir_e                   rd_dir;
    logic [LANES-1:0][AMP_W-1:0] rd_amp;
    logic [LANES-1:0][DUR_W-1:0] rd_dur;
    logic [DUR_W-1:0]            rd_count;

    gcs_profile_mem #(
        .NUM_PROF (NUM_PROF),
        .IDX_W    (IDX_W),
        .N_ON     (N_ON),
        .N_OFF    (N_OFF),
        .AMP_W    (AMP_W),
        .DUR_W    (DUR_W)
    ) mem_i (
        .clk      (clk),
        .wr_en    (cfg_we),
        .wr_block (seq_busy),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_prof  (rd_prof),
        .rd_dir   (rd_dir),
        .rd_amp   (rd_amp),
        .rd_dur   (rd_dur),
        .rd_count (rd_count)
    );

    gcs_seq_core #(
        .IDX_W (IDX_W),
        .LANES (LANES),
        .AMP_W (AMP_W),
        .DUR_W (DUR_W)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_cmd  (pwm_cmd),
        .prof_sel (prof_sel),
        .rd_prof  (rd_prof),
        .rd_dir   (rd_dir),
        .rd_amp   (rd_amp),
        .rd_dur   (rd_dur),
        .rd_count (rd_count),
        .dac_code (dac_code),
        .seq_busy (seq_busy),
        .clamp_en (clamp_en)
    );

    // R1: reset leaves the output stage idle with the clamp engaged.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!seq_busy && clamp_en && (dac_code == '0)));

endmodule

// File: tb/gate_current_sequencer_tb_top.sv
module gate_current_sequencer_tb_top;

    localparam int NP = 8, IW = 4, NON = 6, NOFF = 5, AW = 8, DW = 5;
    localparam int SLOTS = NON + NOFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_cmd = 1'b0;
    logic [3:0]  prof_sel = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [12:0] cfg_wdata = '0;
    logic [7:0]  dac_code;
    logic        seq_busy, clamp_en;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench mirror of profile contents and expected outputs.
    int m_amp [NP][SLOTS];
    int m_dur [NP][SLOTS];
    int m_con [NP];
    int m_coff[NP];
    int l_amp[6], l_dur[6];
    int l_len, l_pos, l_left;
    bit m_pwm = 0, m_dir = 0, e_busy = 0, e_clamp = 1;
    int e_dac = 0;
    logic [3:0] cur_sel = '0;

    always #4 clk = ~clk;

    gate_current_sequencer #(
        .NUM_PROF(NP), .IDX_W(IW), .N_ON(NON), .N_OFF(NOFF), .AMP_W(AW), .DUR_W(DW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .prof_sel(prof_sel),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dac_code(dac_code), .seq_busy(seq_busy), .clamp_en(clamp_en)
    );

    // Build the list of usable segments for one profile and direction.
    task automatic build_list(input int prof, input bit dir);
        int n, cnt, base;
        n    = dir ? NON : NOFF;
        base = dir ? 0 : NON;
        cnt  = dir ? m_con[prof] : m_coff[prof];
        l_len = 0;
        for (int i = 0; i < n; i++) begin
            if (i < cnt && m_dur[prof][base + i] != 0) begin
                l_amp[l_len] = m_amp[prof][base + i];
                l_dur[l_len] = m_dur[prof][base + i];
                l_len++;
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (dac_code !== 8'(e_dac) || seq_busy !== e_busy || clamp_en !== e_clamp) begin
            errors++;
            $display("FAIL %s: dac=%0d busy=%0b clamp=%0b expected dac=%0d busy=%0b clamp=%0b",
                     tag, dac_code, seq_busy, clamp_en, e_dac, e_busy, e_clamp);
        end
    endtask

    // One clock: drive inputs, advance the model, sample after the edge.
    task automatic tick(input bit p, input logic [3:0] s, input bit we,
                        input logic [7:0] a, input logic [12:0] d, input string tag);
        bit was_busy;
        int wp, ww;
        pwm_cmd = p; prof_sel = s; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        cur_sel = s;
        was_busy = e_busy;
        if (p != m_pwm) begin
            build_list((int'(s) < NP) ? int'(s) : 0, p);
            m_dir = p;
            if (p) e_clamp = 0;
            if (l_len > 0) begin
                l_pos = 0; l_left = l_dur[0]; e_dac = l_amp[0]; e_busy = 1;
            end else begin
                e_busy = 0;
                if (!p) e_clamp = 1;
            end
        end else if (e_busy) begin
            l_left--;
            if (l_left == 0) begin
                l_pos++;
                if (l_pos < l_len) begin
                    e_dac = l_amp[l_pos]; l_left = l_dur[l_pos];
                end else begin
                    e_busy = 0;
                    if (!m_dir) e_clamp = 1;
                end
            end
        end
        m_pwm = p;
        wp = int'(a[7:4]); ww = int'(a[3:0]);
        if (we && !was_busy && wp < NP && ww < SLOTS + 2) begin
            if (ww < SLOTS) begin
                m_amp[wp][ww] = int'(d[12:5]); m_dur[wp][ww] = int'(d[4:0]);
            end else if (ww == SLOTS) m_con[wp] = int'(d[4:0]);
            else m_coff[wp] = int'(d[4:0]);
        end
        @(posedge clk); #1;
        check(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(m_pwm, cur_sel, 0, 8'h0, 13'h0, tag);
    endtask

    task automatic wr(input int prof, input int word, input int amp, input int dur);
        tick(m_pwm, cur_sel, 1, {4'(prof), 4'(word)}, {8'(amp), 5'(dur)}, "R9");
    endtask

    task automatic set_list(input int prof, input bit dir, input int cnt);
        for (int i = 0; i < (dir ? NON : NOFF); i++)
            wr(prof, (dir ? 0 : NON) + i, 16 * prof + (dir ? 1 : 8) + i, 1 + ((i + prof) % 3));
        wr(prof, dir ? SLOTS : SLOTS + 1, 0, cnt);
    endtask

    initial begin
        int unsigned seed;
        bit p;
        seed = 32'd11;
        void'($urandom(seed));
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            checks++;
            if (dac_code !== 8'd0 || seq_busy !== 1'b0 || clamp_en !== 1'b1) begin
                errors++;
                $display("FAIL R1: dac=%0d busy=%0b clamp=%0b expected 0 0 1", dac_code, seq_busy, clamp_en);
            end
            @(negedge clk);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // Load every profile with distinct contents (R9).
        for (int pr = 0; pr < NP; pr++) begin
            set_list(pr, 1, NON);
            set_list(pr, 0, NOFF);
        end
        // Profile 1: zero durations inside the turn-on list (R4).
        wr(1, 1, 77, 0); wr(1, 4, 78, 0);
        // Profile 2: short count; profile 3: count beyond the list; profile 4: no turn-on segments.
        wr(2, SLOTS, 0, 2); wr(3, SLOTS, 0, 9); wr(4, SLOTS, 0, 0);

        // R2/R3/R4: turn-on with skipped slots, then turn-off with clamp (R8).
        tick(1, 4'd1, 0, 0, 0, "R2"); idle(14, "R3");
        tick(0, 4'd1, 0, 0, 0, "R2"); idle(14, "R8");
        // R4: count 2 and count beyond list.
        tick(1, 4'd2, 0, 0, 0, "R4"); idle(8, "R4");
        tick(0, 4'd2, 0, 0, 0, "R4"); idle(12, "R4");
        tick(1, 4'd3, 0, 0, 0, "R4"); idle(16, "R4");
        tick(0, 4'd3, 0, 0, 0, "R5"); idle(12, "R5");
        // R5: no usable turn-on segment leaves busy low, dac held.
        tick(1, 4'd4, 0, 0, 0, "R5"); idle(3, "R5");
        tick(0, 4'd4, 0, 0, 0, "R8"); idle(12, "R8");
        // R6: selection changes mid-sequence have no effect.
        tick(1, 4'd5, 0, 0, 0, "R6");
        tick(1, 4'd6, 0, 0, 0, "R6"); tick(1, 4'd2, 0, 0, 0, "R6"); idle(14, "R6");
        // R6: out-of-range index uses profile 0.
        tick(0, 4'd12, 0, 0, 0, "R6"); idle(12, "R6");
        // R10: writes while busy are ignored, then profile 6 is replayed.
        tick(1, 4'd6, 0, 0, 0, "R10");
        wr(6, 0, 200, 7); wr(6, SLOTS, 0, 1);
        idle(14, "R10");
        // R10: out-of-range writes ignored.
        wr(9, 0, 99, 3); wr(6, 14, 99, 3);
        tick(0, 4'd6, 0, 0, 0, "R10"); idle(12, "R10");
        tick(1, 4'd6, 0, 0, 0, "R10"); idle(14, "R10");
        // R7/R8: abort turn-off right after it starts, clamp stays low.
        tick(0, 4'd1, 0, 0, 0, "R7"); idle(1, "R7");
        tick(1, 4'd2, 0, 0, 0, "R7"); idle(2, "R8");
        tick(0, 4'd3, 0, 0, 0, "R7"); idle(12, "R7");

        // Random mix of edges, selections and writes.
        p = 0;
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 2) p = ~m_pwm; else p = m_pwm;
            if (r == 3 || r == 4 || r == 5)
                tick(p, 4'($urandom), 1, {4'($urandom % 10), 4'($urandom)},
                     {8'($urandom), 5'($urandom % 4)}, "R10");
            else
                tick(p, 4'($urandom), 0, 0, 0, (p != m_pwm) ? "R7" : "R3");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule